// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block tracks loads that a compiler has hoisted above stores which might write the same memory. When such a load issues early, it records an entry keyed by the number of the register it writes, together with the byte address and access width. Each later store sweeps every live entry in parallel, and any entry whose byte range it touches is dropped. When the program later reaches the point where the load originally sat, it asks the table about that register. A hit means no conflicting store intervened and the early value may be used. A miss means the caller must reload or branch to recovery code. That follow-up is not part of this block.

The table has `DEPTH` slots, 16 by default. Each slot is a two-state machine. `SLOT_EMPTY` moves to `SLOT_ARMED` on a write, which is the *arm* transition. `SLOT_ARMED` returns to `SLOT_EMPTY` on one of three transitions: *store-kill* (an overlapping store), *check-clear* (a successful check issued with clear mode), or *flush* (invalidate-all). A write to an armed slot is the *rearm* transition, which reloads its fields and leaves it armed.

A new allocation picks its slot in this order:
1. The slot already holding the same register tag.
2. Otherwise, the lowest-numbered empty slot.
3. Otherwise, the slot named by a round-robin pointer. The pointer moves on only when it is used.

Within one cycle, the table applies flush, store-kill and check-clear first and the new allocation after them. Check results are combinational and reflect the contents at the start of the cycle.

Top module: `spec_load_table`

## Requirements
- R1: After reset every slot is empty, so a check on any register tag reports a miss.
- R2: A check (`chk_en`=1) on a tag that has been allocated and not invalidated raises `chk_hit` in the same cycle. A check on a tag with no live entry raises `chk_miss`. When `chk_en`=0, both outputs are low.
- R3: The size code s selects 2^s bytes (0=1, 1=2, 2=4, 3=8) starting at the address. A store whose byte range does not intersect an entry's range leaves that entry live.
- R4: A store whose byte range intersects an entry's range in even a single byte, at either end, invalidates that entry.
- R5: Allocating a tag that already has a live entry overwrites that entry in place. The old address no longer matters, and no second entry for the tag exists.
- R6: A new tag takes the lowest-numbered empty slot. When no slot is empty, it evicts the slot at the round-robin pointer, which starts at 0 after reset and advances by one only on such an eviction.
- R7: A check with `chk_clear`=1 that hits empties that entry, so the next check on that tag misses. A check with `chk_clear`=0 leaves the entry live.
- R8: When a store and an allocation with overlapping ranges occur in the same cycle, the store is applied first and the new entry remains live.
- R9: `flush_all` empties every slot in one cycle. An allocation in the same cycle is applied after the flush and survives it.
- R10: A check sees the table as it stood at the start of the cycle. A store in the same cycle that kills the entry does not turn that check into a miss, but the next check misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Empty every slot |
| ld_en | input | 1 | Allocate an entry for an early load |
| ld_tag | input | TAG_W | Destination register number of the early load |
| ld_addr | input | ADDR_W | Byte address of the early load |
| ld_size | input | SZ_W | Size code of the early load (2^code bytes) |
| st_en | input | 1 | A store is executing |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | SZ_W | Size code of the store (2^code bytes) |
| chk_en | input | 1 | Check request |
| chk_tag | input | TAG_W | Register number being checked |
| chk_clear | input | 1 | Empty the entry if the check hits |
| chk_hit | output | 1 | Check found a live entry |
| chk_miss | output | 1 | Check found no live entry; speculation failed |

## Verification
A slot left armed after an overlapping store shows up as a false `chk_hit` on the very next check of that tag, and that error is unsafe because it lets stale data through. A slot wrongly emptied, or a duplicate entry for one tag, shows up as an unexpected `chk_miss`. That can be seen only when the tag is checked, which may be many cycles later. A replacement pointer that drifts, or a free slot that is skipped, is visible only indirectly. The wrong victim disappears, so the bench fills the table and checks both the evicted tag and its neighbours right after each eviction.

// File: rtl/spec_tbl_pkg.sv
package spec_tbl_pkg;

    // Life cycle of one table slot.
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

endpackage

// File: rtl/spec_tbl_slot.sv
module spec_tbl_slot
    import spec_tbl_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic              clr,
    input  logic              wr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SZ_W-1:0]   wr_size,
    output logic              valid,
    output logic [TAG_W-1:0]  tag
);

    // One extra bit keeps range ends from wrapping at the top of memory.
    localparam int SPAN_W = ADDR_W + 1;
    localparam logic [SPAN_W-1:0] ONE = SPAN_W'(1);

    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]   size_q;

    logic [SPAN_W-1:0] own_lo, own_hi, st_lo, st_hi;
    logic              st_overlap;

    always_comb begin
        own_lo     = {1'b0, addr_q};
        own_hi     = own_lo + (ONE << size_q) - ONE;
        st_lo      = {1'b0, st_addr};
        st_hi      = st_lo + (ONE << st_size) - ONE;
        st_overlap = st_en && (state_q == SLOT_ARMED)
                     && (st_lo <= own_hi) && (own_lo <= st_hi);
    end

    // Next state: a write (arm/rearm) outranks flush, store-kill and check-clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr) state_d = SLOT_ARMED;
            end
            SLOT_ARMED: begin
                if (wr)                              state_d = SLOT_ARMED;
                else if (flush || st_overlap || clr) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            addr_q <= '0;
            size_q <= '0;
        end else if (wr) begin
            tag_q  <= wr_tag;
            addr_q <= wr_addr;
            size_q <= wr_size;
        end
    end

    always_comb begin
        valid = (state_q == SLOT_ARMED);
        tag   = tag_q;
    end

    // R4
    store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overlap && !wr) |=> !valid);

    // R8
    arm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (valid && tag == $past(wr_tag)));

endmodule

// File: rtl/spec_tbl_victim.sv
module spec_tbl_victim #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid_vec,
    input  logic             take,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic             evict;

    // Lowest-numbered empty slot: scan downward so the smallest index wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        evict = take && !any_free;
        idx   = any_free ? free_idx : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (evict) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evict |=> $stable(ptr_q));

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import spec_tbl_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              ld_en,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic              chk_en,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    output logic              chk_hit,
    output logic              chk_miss
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_vec;
    logic [TAG_W-1:0] tag_arr [DEPTH];
    logic [DEPTH-1:0] chk_match, ld_match, clr_vec, wr_vec;
    logic             chk_found, ld_reuse, take;
    logic [IDX_W-1:0] victim_idx;

    // Tag lookups for the check port and the allocation port.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            chk_match[i] = valid_vec[i] && (tag_arr[i] == chk_tag);
            ld_match[i]  = valid_vec[i] && (tag_arr[i] == ld_tag);
        end
        chk_found = |chk_match;
        ld_reuse  = |ld_match;
        take      = ld_en && !ld_reuse;
        chk_hit   = chk_en && chk_found;
        chk_miss  = chk_en && !chk_found;
        clr_vec   = (chk_en && chk_clear) ? chk_match : '0;
    end

    spec_tbl_victim #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .take      (take),
        .idx       (victim_idx)
    );

    // Write select: same tag first, otherwise the victim picker's choice.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!ld_en)        wr_vec[i] = 1'b0;
            else if (ld_reuse) wr_vec[i] = ld_match[i];
            else               wr_vec[i] = (victim_idx == IDX_W'(i));
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        spec_tbl_slot #(
            .TAG_W  (TAG_W),
            .ADDR_W (ADDR_W),
            .SZ_W   (SZ_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush_all),
            .st_en   (st_en),
            .st_addr (st_addr),
            .st_size (st_size),
            .clr     (clr_vec[g]),
            .wr      (wr_vec[g]),
            .wr_tag  (ld_tag),
            .wr_addr (ld_addr),
            .wr_size (ld_size),
            .valid   (valid_vec[g]),
            .tag     (tag_arr[g])
        );
    end

    // R5
    one_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_match) && $onehot0(chk_match));

    // R2
    chk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_hit && chk_miss));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !ld_en) |=> (valid_vec == '0));

    // R9
    flush_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && ld_en) |=> ($countones(valid_vec) == 1));

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_hit && chk_clear && !ld_en && !flush_all) |=> ($countones(valid_vec) < $countones($past(valid_vec))));

endmodule

// File: tb/spec_load_table_tb.sv
module spec_load_table_tb;

    typedef enum logic [2:0] {
        OP_ALLOC, OP_STORE, OP_CHECK, OP_CHKCLR, OP_FLUSH
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [6:0]  tag;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VECS [NVEC] = '{
        '{OP_CHECK,  7'd3, 32'h0,     2'd0, 1'b0, 4'd1},  // R1 empty after reset
        '{OP_ALLOC,  7'd3, 32'h100,   2'd2, 1'b0, 4'd2},
        '{OP_CHECK,  7'd3, 32'h0,     2'd0, 1'b1, 4'd2},  // R2 hit
        '{OP_CHECK,  7'd4, 32'h0,     2'd0, 1'b0, 4'd2},  // R2 other tag misses
        '{OP_ALLOC,  7'd4, 32'h200,   2'd3, 1'b0, 4'd2},
        '{OP_STORE,  7'd0, 32'h104,   2'd2, 1'b0, 4'd3},  // R3 adjacent, no overlap
        '{OP_CHECK,  7'd3, 32'h0,     2'd0, 1'b1, 4'd3},
        '{OP_STORE,  7'd0, 32'h207,   2'd0, 1'b0, 4'd4},  // R4 last byte
        '{OP_CHECK,  7'd4, 32'h0,     2'd0, 1'b0, 4'd4},
        '{OP_STORE,  7'd0, 32'h0FF,   2'd1, 1'b0, 4'd4},  // R4 first byte
        '{OP_CHECK,  7'd3, 32'h0,     2'd0, 1'b0, 4'd4},
        '{OP_ALLOC,  7'd5, 32'h300,   2'd2, 1'b0, 4'd5},
        '{OP_ALLOC,  7'd5, 32'h400,   2'd2, 1'b0, 4'd5},  // R5 replace
        '{OP_STORE,  7'd0, 32'h300,   2'd3, 1'b0, 4'd5},
        '{OP_CHECK,  7'd5, 32'h0,     2'd0, 1'b1, 4'd5},
        '{OP_STORE,  7'd0, 32'h402,   2'd0, 1'b0, 4'd5},
        '{OP_CHECK,  7'd5, 32'h0,     2'd0, 1'b0, 4'd5},
        '{OP_ALLOC,  7'd6, 32'h500,   2'd0, 1'b0, 4'd7},
        '{OP_CHKCLR, 7'd6, 32'h0,     2'd0, 1'b1, 4'd7},  // R7 clear
        '{OP_CHECK,  7'd6, 32'h0,     2'd0, 1'b0, 4'd7},
        '{OP_ALLOC,  7'd7, 32'h600,   2'd0, 1'b0, 4'd7},
        '{OP_CHECK,  7'd7, 32'h0,     2'd0, 1'b1, 4'd7},  // R7 plain check keeps
        '{OP_CHECK,  7'd7, 32'h0,     2'd0, 1'b1, 4'd7},
        '{OP_FLUSH,  7'd0, 32'h0,     2'd0, 1'b0, 4'd9},  // R9
        '{OP_CHECK,  7'd7, 32'h0,     2'd0, 1'b0, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all = 1'b0;
    logic        ld_en = 1'b0;
    logic [6:0]  ld_tag = '0;
    logic [31:0] ld_addr = '0;
    logic [1:0]  ld_size = '0;
    logic        st_en = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_en = 1'b0;
    logic [6:0]  chk_tag = '0;
    logic        chk_clear = 1'b0;
    logic        chk_hit, chk_miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;

    spec_load_table u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_all (flush_all),
        .ld_en     (ld_en),
        .ld_tag    (ld_tag),
        .ld_addr   (ld_addr),
        .ld_size   (ld_size),
        .st_en     (st_en),
        .st_addr   (st_addr),
        .st_size   (st_size),
        .chk_en    (chk_en),
        .chk_tag   (chk_tag),
        .chk_clear (chk_clear),
        .chk_hit   (chk_hit),
        .chk_miss  (chk_miss)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    // One cycle: drive after the falling edge, sample the combinational
    // check outputs 2 ns later, then let the rising edge commit.
    task automatic step(input logic a, input logic [6:0] at, input logic [31:0] aa,
                        input logic [1:0] az, input logic s, input logic [31:0] sa,
                        input logic [1:0] sz, input logic c, input logic [6:0] ct,
                        input logic cc, input logic f, input logic exp_hit,
                        input string req);
        @(negedge clk);
        ld_en = a; ld_tag = at; ld_addr = aa; ld_size = az;
        st_en = s; st_addr = sa; st_size = sz;
        chk_en = c; chk_tag = ct; chk_clear = cc; flush_all = f;
        #2;
        checks = checks + 1;
        if (c) begin
            if (chk_hit !== exp_hit || chk_miss !== !exp_hit) begin
                errors = errors + 1;
                $display("FAIL %s tag %0d: actual hit=%b miss=%b expected hit=%b miss=%b",
                         req, ct, chk_hit, chk_miss, exp_hit, !exp_hit);
            end
        end else if (chk_hit !== 1'b0 || chk_miss !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL %s idle: actual hit=%b miss=%b expected hit=0 miss=0",
                     req, chk_hit, chk_miss);
        end
        @(posedge clk);
    endtask

    task automatic chk(input logic [6:0] t, input logic e, input string req);
        step(0, 0, 0, 0, 0, 0, 0, 1, t, 0, 0, e, req);
    endtask

    task automatic alloc(input logic [6:0] t, input logic [31:0] ad, input logic [1:0] z);
        step(1, t, ad, z, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            step(v.op == OP_ALLOC, v.tag, v.addr, v.sz,
                 v.op == OP_STORE, v.addr, v.sz,
                 (v.op == OP_CHECK) || (v.op == OP_CHKCLR), v.tag,
                 v.op == OP_CHKCLR, v.op == OP_FLUSH, v.exp_hit,
                 $sformatf("R%0d", v.req));
        end

        // R8: overlapping store and allocation in one cycle
        step(1, 7'd10, 32'h800, 2'd2, 1, 32'h800, 2'd2, 0, 0, 0, 0, 0, "R8");
        chk(7'd10, 1'b1, "R8");

        // R10: same-cycle store does not affect the check, the next one misses
        step(0, 0, 0, 0, 1, 32'h802, 2'd0, 1, 7'd10, 0, 0, 1'b1, "R10");
        chk(7'd10, 1'b0, "R10");

        // R9: allocation in the flush cycle survives it
        alloc(7'd12, 32'h900, 2'd0);
        step(1, 7'd11, 32'hA00, 2'd0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        chk(7'd12, 1'b0, "R9");
        chk(7'd11, 1'b1, "R9");

        // R6: fill, then round-robin evictions, then free slot preferred
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        for (int k = 0; k < 16; k++) alloc(7'(20 + k), 32'h1000 + 32'(k * 16), 2'd0);
        chk(7'd20, 1'b1, "R6");
        chk(7'd35, 1'b1, "R6");
        alloc(7'd40, 32'h2000, 2'd0);
        chk(7'd20, 1'b0, "R6");
        chk(7'd21, 1'b1, "R6");
        chk(7'd40, 1'b1, "R6");
        alloc(7'd41, 32'h2010, 2'd0);
        chk(7'd21, 1'b0, "R6");
        chk(7'd22, 1'b1, "R6");
        step(0, 0, 0, 0, 1, 32'h1050, 2'd0, 0, 0, 0, 0, 0, "R6");
        chk(7'd25, 1'b0, "R6");
        alloc(7'd42, 32'h2020, 2'd0);
        chk(7'd22, 1'b1, "R6");
        chk(7'd42, 1'b1, "R6");
        chk(7'd41, 1'b1, "R6");

        finish_run();
    end

endmodule